// File: doc/BRIEF.md
# Speech Frame Energy and Word Boundary Detector

This block takes a stream of signed 16-bit audio samples (nominally 8 kHz, one sample per `smp_valid` pulse) and finds where a spoken word starts and stops. Each accepted sample passes through a first-order high-boost filter. It is then weighted by a Hamming taper and squared. The squares are summed into frames of 160 samples. A new frame begins every 80 samples, so each sample contributes to two frames.

Every finished frame is reported on `frame_done` together with its 48-bit energy. A small decision machine compares each frame energy against two thresholds. It raises `word_start` after a run of loud frames and `word_end` after a run of quiet frames, and it holds `speech_active` high between the two. A downstream recogniser uses these events to cut the word out of the sample stream.

Top module: `speech_endpoint_detector`

## Requirements
- R1: The filtered value is y[n] = x[n] − ((31130 · x[n−1]) >>> 15), where >>> is an arithmetic shift (floor). x[−1] is 0 after reset. y is kept to 17 signed bits without loss.
- R2: The taper coefficient for frame position p (0..159) is w[p] = floor((0.54 − 0.46·cos(2π·p/159))·32768 + 0.5). It is an unsigned Q15 value fixed at elaboration.
- R3: A frame's energy is the sum over p = 0..159 of (floor(y·w[p] / 32768))². It is carried in 48 bits and never wraps.
- R4: Frame k covers accepted samples 80k to 80k+159. The first frame is complete after 160 samples, and each further frame after 80 more.
- R5: If a frame's last sample is accepted at rising edge n, `frame_done` is high from edge n+2 to edge n+3 and low otherwise. `frame_energy` is valid while `frame_done` is high.
- R6: Cycles with `smp_valid` low change neither the filter history, the frame position nor any energy sum.
- R7: While `speech_active` is low, 3 consecutive frames whose energy is strictly greater than the upper threshold make `word_start` pulse for one cycle. The pulse comes on the edge after the third frame's `frame_done`, and `speech_active` rises on that same edge.
- R8: While `speech_active` is high, 5 consecutive frames whose energy is strictly less than the lower threshold make `word_end` pulse for one cycle. The pulse comes on the edge after the fifth frame's `frame_done`, and `speech_active` falls on that same edge.
- R9: A frame that does not meet the condition for the current state restarts the consecutive-frame run from zero.
- R10: A synchronous active-low reset clears all outputs, the filter history, the frame position and the decision state. After reset the framing starts over at sample 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Sample on `smp_data` is accepted this cycle |
| smp_data | input | 16 | Signed audio sample |
| frame_done | output | 1 | One-cycle strobe: a frame energy is ready |
| frame_energy | output | 48 | Energy of the frame just finished |
| speech_active | output | 1 | High between a word start and its word end |
| word_start | output | 1 | One-cycle strobe at the start of a word |
| word_end | output | 1 | One-cycle strobe at the end of a word |

## Verification
A corrupt filter history or taper entry appears at `frame_energy` at the next strobe and keeps corrupting the next frame as well, because each sample lands in two frames. A slip in the frame position counter moves `frame_done` away from its expected cycle within at most 80 samples. A miscounted decision run shows up as a `word_start`, `word_end` or `speech_active` mismatch one cycle after the frame that should have (or should not have) closed the run. The bench therefore compares every strobe's cycle and energy, and every cycle's decision outputs, against an arithmetic model. It drives loud, mid-level, quiet, full-scale and silent stretches, with and without idle gaps, and includes a reset in the middle of a frame.

// File: rtl/spd_pkg.sv
// Package: shared constants, types and the elaboration-time taper function
// for the speech endpoint detector. Assumes Q15 fixed point throughout.
package spd_pkg;

    localparam int FRAC_BITS = 15;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_VOICE = 1'b1
    } ep_state_t;

    // Hamming taper value for position idx of a len-long frame, Q15 rounded
    function automatic logic [15:0] hamming_q15(input int idx, input int len);
        real ang;
        real val;
        ang = 2.0 * 3.14159265358979 * real'(idx) / real'(len - 1);
        val = (0.54 - 0.46 * $cos(ang)) * 32768.0 + 0.5;
        return 16'($rtoi(val));
    endfunction

endpackage

// File: rtl/spd_preemph.sv
// Module: first-order high-boost filter y = x - c*x_prev (c in Q15).
// Assumes one sample per in_valid; history is touched only on accepted
// samples. Output is registered, so y appears one edge after acceptance.
module spd_preemph #(
    parameter int SAMPLE_W = 16,
    parameter int COEF_Q15 = 31130,
    localparam int Y_W     = SAMPLE_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    output logic                       y_valid,
    output logic signed [Y_W-1:0]      y_data
);
    localparam logic signed [SAMPLE_W:0] COEF = (SAMPLE_W + 1)'(COEF_Q15);

    logic signed [SAMPLE_W-1:0]   x_prev;
    logic signed [2*SAMPLE_W+1:0] prod;
    logic signed [Y_W-1:0]        scaled;
    logic signed [Y_W-1:0]        y_next;

    // Scaled previous sample, floored by arithmetic shift
    always_comb begin
        prod   = $signed({x_prev[SAMPLE_W-1], x_prev}) * COEF;
        scaled = Y_W'(prod >>> spd_pkg::FRAC_BITS);
        y_next = $signed({in_sample[SAMPLE_W-1], in_sample}) - scaled;
    end

    // History and output register, updated only on accepted samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_prev  <= '0;
            y_valid <= 1'b0;
            y_data  <= '0;
        end else begin
            y_valid <= in_valid;
            if (in_valid) begin
                x_prev <= in_sample;
                y_data <= y_next;
            end
        end
    end

    localparam logic signed [Y_W-1:0] Y_MAX = Y_W'((1 <<< (SAMPLE_W - 1)) - 1 + COEF_Q15);
    localparam logic signed [Y_W-1:0] Y_MIN = Y_W'(-(1 <<< (SAMPLE_W - 1)) - COEF_Q15);

    AST_Y_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |-> (y_data <= Y_MAX && y_data >= Y_MIN)); // R1

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(x_prev)); // R6

endmodule

// File: rtl/spd_window_rom.sv
// Module: read-only taper table, one Q15 entry per frame position, filled
// at elaboration from spd_pkg::hamming_q15. Pure combinational lookup;
// positions beyond the frame read as zero.
module spd_window_rom #(
    parameter int FRAME_LEN = 160,
    localparam int POS_W    = $clog2(FRAME_LEN)
) (
    input  logic [POS_W-1:0] pos,
    output logic [15:0]      coef
);
    logic [15:0] table_q [FRAME_LEN];

    for (genvar i = 0; i < FRAME_LEN; i++) begin : g_entry
        assign table_q[i] = spd_pkg::hamming_q15(i, FRAME_LEN);
    end

    // Guarded lookup of the addressed entry
    always_comb begin
        coef = (pos < POS_W'(FRAME_LEN)) ? table_q[pos] : '0;
    end

endmodule

// File: rtl/spd_energy_lane.sv
// Module: one frame accumulator. Tapers each filtered sample at its frame
// position, squares it (stage A) and sums the squares (stage B). Position 0
// restarts the sum; position FRAME_LEN-1 closes it and pulses done.
// Assumes in_pos walks 0..FRAME_LEN-1 on successive in_valid cycles.
module spd_energy_lane #(
    parameter int SAMPLE_W  = 16,
    parameter int FRAME_LEN = 160,
    parameter int ENERGY_W  = 48,
    localparam int Y_W      = SAMPLE_W + 1,
    localparam int POS_W    = $clog2(FRAME_LEN),
    localparam int SQ_W     = 2 * Y_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic signed [Y_W-1:0] in_y,
    input  logic [POS_W-1:0]      in_pos,
    output logic                  done,
    output logic [ENERGY_W-1:0]   energy
);
    logic [15:0]            coef;
    logic signed [Y_W+16:0] tap_prod;
    logic signed [Y_W-1:0]  tapered;
    logic signed [SQ_W-1:0] sq_signed;
    logic [SQ_W-1:0]        sq_q;
    logic                   sq_valid;
    logic                   sq_first;
    logic                   sq_last;
    logic [ENERGY_W-1:0]    acc;
    logic [ENERGY_W-1:0]    acc_next;

    spd_window_rom #(.FRAME_LEN(FRAME_LEN)) rom_i (
        .pos  (in_pos),
        .coef (coef)
    );

    // Taper and square the incoming filtered sample
    always_comb begin
        tap_prod  = in_y * $signed({1'b0, coef});
        tapered   = Y_W'(tap_prod >>> spd_pkg::FRAC_BITS);
        sq_signed = tapered * tapered;
    end

    // Stage A: register the square and its frame-position flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q     <= '0;
            sq_valid <= 1'b0;
            sq_first <= 1'b0;
            sq_last  <= 1'b0;
        end else begin
            sq_valid <= in_valid;
            sq_q     <= SQ_W'(sq_signed);
            sq_first <= (in_pos == '0);
            sq_last  <= (in_pos == POS_W'(FRAME_LEN - 1));
        end
    end

    // Running sum, restarted at the first position of a frame
    always_comb begin
        acc_next = (sq_first ? '0 : acc) + {{(ENERGY_W - SQ_W){1'b0}}, sq_q};
    end

    // Stage B: accumulate and publish the closed frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            done   <= 1'b0;
            energy <= '0;
        end else begin
            done <= 1'b0;
            if (sq_valid) begin
                acc <= acc_next;
                if (sq_last) begin
                    done   <= 1'b1;
                    energy <= acc_next;
                end
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && !sq_first) |=> (acc >= $past(acc))); // R3

    AST_SQ_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (sq_signed >= 0)); // R3

endmodule

// File: rtl/spd_endpoint_fsm.sv
// Module: word boundary decision. Counts consecutive frames above the upper
// threshold while quiet and below the lower threshold while voiced; a full
// run flips the state and pulses the matching event. Registered outputs,
// one edge after the frame strobe.
module spd_endpoint_fsm #(
    parameter int                ENERGY_W  = 48,
    parameter logic [ENERGY_W-1:0] HI_THRESH = 48'd2_000_000_000,
    parameter logic [ENERGY_W-1:0] LO_THRESH = 48'd200_000_000,
    parameter int                START_RUN = 3,
    parameter int                END_RUN   = 5,
    localparam int               RUN_MAX   = (START_RUN > END_RUN) ? START_RUN : END_RUN,
    localparam int               CNT_W     = $clog2(RUN_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_done,
    input  logic [ENERGY_W-1:0] frame_energy,
    output logic                speech_active,
    output logic                word_start,
    output logic                word_end
);
    spd_pkg::ep_state_t state;
    logic [CNT_W-1:0]   run_cnt;
    logic               loud;
    logic               quiet;

    // Threshold comparisons for the frame on the input
    always_comb begin
        loud  = frame_energy > HI_THRESH;
        quiet = frame_energy < LO_THRESH;
    end

    // State, run counter and event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= spd_pkg::ST_QUIET;
            run_cnt    <= '0;
            word_start <= 1'b0;
            word_end   <= 1'b0;
        end else begin
            word_start <= 1'b0;
            word_end   <= 1'b0;
            if (frame_done) begin
                if (state == spd_pkg::ST_QUIET) begin
                    if (!loud) begin
                        run_cnt <= '0;
                    end else if (run_cnt == CNT_W'(START_RUN - 1)) begin
                        run_cnt    <= '0;
                        state      <= spd_pkg::ST_VOICE;
                        word_start <= 1'b1;
                    end else begin
                        run_cnt <= run_cnt + 1'b1;
                    end
                end else begin
                    if (!quiet) begin
                        run_cnt <= '0;
                    end else if (run_cnt == CNT_W'(END_RUN - 1)) begin
                        run_cnt  <= '0;
                        state    <= spd_pkg::ST_QUIET;
                        word_end <= 1'b1;
                    end else begin
                        run_cnt <= run_cnt + 1'b1;
                    end
                end
            end
        end
    end

    assign speech_active = (state == spd_pkg::ST_VOICE);

    AST_START_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        word_start |-> ($past(frame_done) && $past(frame_energy) > HI_THRESH)); // R7

    AST_START_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        word_start |-> (speech_active && !$past(speech_active))); // R7

    AST_END_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        word_end |-> ($past(frame_done) && $past(frame_energy) < LO_THRESH)); // R8

    AST_END_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        word_end |-> (!speech_active && $past(speech_active))); // R8

    AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt < CNT_W'(RUN_MAX)); // R9

endmodule

// File: rtl/speech_endpoint_detector.sv
// Module (top): filter -> overlapped framing -> energy -> word boundaries.
// Overlap is realised with FRAME_LEN/HOP_LEN accumulator lanes fed the same
// filtered sample at offset frame positions, so no sample store is needed.
// Assumes FRAME_LEN is a multiple of HOP_LEN.
module speech_endpoint_detector #(
    parameter int                  SAMPLE_W  = 16,
    parameter int                  FRAME_LEN = 160,
    parameter int                  HOP_LEN   = 80,
    parameter int                  COEF_Q15  = 31130,
    parameter int                  ENERGY_W  = 48,
    parameter logic [ENERGY_W-1:0] HI_THRESH = 48'd2_000_000_000,
    parameter logic [ENERGY_W-1:0] LO_THRESH = 48'd200_000_000,
    parameter int                  START_RUN = 3,
    parameter int                  END_RUN   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [15:0]         smp_data,
    output logic                frame_done,
    output logic [47:0]         frame_energy,
    output logic                speech_active,
    output logic                word_start,
    output logic                word_end
);
    localparam int NUM_LANES = FRAME_LEN / HOP_LEN;
    localparam int POS_W     = $clog2(FRAME_LEN);
    localparam int Y_W       = SAMPLE_W + 1;

    logic                   y_valid;
    logic signed [Y_W-1:0]  y_data;
    logic [POS_W-1:0]       pos;
    logic [NUM_LANES-1:0]   started;
    logic [NUM_LANES-1:0]   lane_go;
    logic [NUM_LANES-1:0]   lane_done;
    logic [POS_W-1:0]       lane_pos [NUM_LANES];
    logic [ENERGY_W-1:0]    lane_energy [NUM_LANES];
    logic [ENERGY_W-1:0]    energy_mux;

    spd_preemph #(
        .SAMPLE_W (SAMPLE_W),
        .COEF_Q15 (COEF_Q15)
    ) pre_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (smp_valid),
        .in_sample ($signed(smp_data[SAMPLE_W-1:0])),
        .y_valid   (y_valid),
        .y_data    (y_data)
    );

    // Shared frame position of the filtered stream, wraps every frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (y_valid) begin
            pos <= (pos == POS_W'(FRAME_LEN - 1)) ? '0 : pos + 1'b1;
        end
    end

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        localparam int OFFSET = k * HOP_LEN;

        // Lane k becomes live when the stream reaches its starting offset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                started[k] <= 1'b0;
            end else if (y_valid && pos == POS_W'(OFFSET)) begin
                started[k] <= 1'b1;
            end
        end

        // Frame position as seen by lane k
        always_comb begin
            int diff;
            diff = int'(pos) - OFFSET;
            if (diff < 0) diff = diff + FRAME_LEN;
            lane_pos[k] = POS_W'(diff);
            lane_go[k]  = y_valid && (started[k] || pos == POS_W'(OFFSET));
        end

        spd_energy_lane #(
            .SAMPLE_W  (SAMPLE_W),
            .FRAME_LEN (FRAME_LEN),
            .ENERGY_W  (ENERGY_W)
        ) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (lane_go[k]),
            .in_y     (y_data),
            .in_pos   (lane_pos[k]),
            .done     (lane_done[k]),
            .energy   (lane_energy[k])
        );
    end

    // Merge the (at most one) finishing lane onto the frame outputs
    always_comb begin
        energy_mux = '0;
        for (int k = 0; k < NUM_LANES; k++) begin
            if (lane_done[k]) energy_mux = energy_mux | lane_energy[k];
        end
    end

    assign frame_done   = |lane_done;
    assign frame_energy = 48'(energy_mux);

    spd_endpoint_fsm #(
        .ENERGY_W  (ENERGY_W),
        .HI_THRESH (HI_THRESH),
        .LO_THRESH (LO_THRESH),
        .START_RUN (START_RUN),
        .END_RUN   (END_RUN)
    ) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_done    (frame_done),
        .frame_energy  (energy_mux),
        .speech_active (speech_active),
        .word_start    (word_start),
        .word_end      (word_end)
    );

    AST_ONE_LANE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_done)); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R5

    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_start && word_end)); // R8

endmodule

// File: tb/speech_endpoint_detector_tb.sv
`timescale 1ns/1ps
module speech_endpoint_detector_tb_top;
    localparam int FL  = 160;
    localparam int HOP = 80;
    localparam int NB  = 32;
    localparam int NS  = NB * HOP;
    localparam int NF  = (NS - FL) / HOP + 1;
    localparam logic [47:0] HI = 48'd2_000_000_000;
    localparam logic [47:0] LO = 48'd200_000_000;

    localparam int RUN_A [NB] = '{0,0,1,3,3,3,3,3,0,0,0,0,0,0,0,0,
                                  3,3,0,0,0,3,3,3,3,2,2,1,0,0,0,0};
    localparam int RUN_B [NB] = '{4,4,4,4,0,0,0,0,2,0,0,0,0,0,0,1,
                                  1,3,4,3,1,0,0,0,0,0,0,0,0,2,2,0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        frame_done;
    logic [47:0] frame_energy;
    logic        speech_active;
    logic        word_start;
    logic        word_end;

    speech_endpoint_detector #(
        .HI_THRESH (HI),
        .LO_THRESH (LO)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .smp_valid     (smp_valid),
        .smp_data      (smp_data),
        .frame_done    (frame_done),
        .frame_energy  (frame_energy),
        .speech_active (speech_active),
        .word_start    (word_start),
        .word_end      (word_end)
    );

    always #2.5 clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int     vectors = 0;
    int     errors  = 0;
    bit     finished = 0;
    longint xs [NS];
    longint exp_e [NF];
    int unsigned done_cyc [NF];
    longint wtab [FL];

    bit mon_en = 0;
    int frames_seen = 0;
    bit model_active = 0;
    bit pend_start = 0;
    bit pend_end = 0;
    int run_cnt = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, expv, cyc);
        end
    endtask

    // R2 taper, computed from its formula
    task automatic build_taper();
        for (int p = 0; p < FL; p++) begin
            real v;
            v = (0.54 - 0.46 * $cos(2.0 * 3.14159265358979 * real'(p) / real'(FL - 1))) * 32768.0 + 0.5;
            wtab[p] = longint'($rtoi(v));
        end
    endtask

    // Stimulus for one run and the R1/R3 expected frame energies
    task automatic build_run(input int run);
        int unsigned lcg;
        longint xprev;
        longint ys [NS];
        lcg = (run == 0) ? 32'h1234_5678 : 32'h0bad_f00d;
        for (int n = 0; n < NS; n++) begin
            int code;
            int amp;
            code = (run == 0) ? RUN_A[n / HOP] : RUN_B[n / HOP];
            amp = (code == 1) ? 500 : (code == 2) ? 4000 : (code == 3) ? 16000 : 0;
            lcg = lcg * 32'd1103515245 + 32'd12345;
            if (code == 4) xs[n] = (n % 2 == 0) ? 32767 : -32768;
            else if (amp == 0) xs[n] = 0;
            else xs[n] = longint'((lcg >> 8) % (2 * amp + 1)) - amp;
        end
        xprev = 0;
        for (int n = 0; n < NS; n++) begin
            ys[n] = xs[n] - ((31130 * xprev) >>> 15);
            xprev = xs[n];
        end
        for (int k = 0; k < NF; k++) begin
            longint e;
            e = 0;
            for (int p = 0; p < FL; p++) begin
                longint t;
                t = (ys[k * HOP + p] * wtab[p]) >>> 15;
                e += t * t;
            end
            exp_e[k] = e;
        end
    endtask

    task automatic reset_model();
        frames_seen = 0;
        model_active = 0;
        pend_start = 0;
        pend_end = 0;
        run_cnt = 0;
    endtask

    // Drive one run; gaps exercise R6
    task automatic drive_run(input bit gaps);
        for (int n = 0; n < NS; n++) begin
            if (gaps && (n % 7 == 3)) begin
                repeat ((n % 3) + 1) begin
                    @(negedge clk);
                    smp_valid = 1'b0;
                    smp_data = 16'hDEAD;
                end
            end
            @(negedge clk);
            smp_valid = 1'b1;
            smp_data = 16'(xs[n]);
            if (n >= FL - 1 && ((n - (FL - 1)) % HOP) == 0)
                done_cyc[(n - (FL - 1)) / HOP] = cyc + 3;
        end
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    // Per-cycle monitor of strobes, energies and decisions
    always @(negedge clk) begin
        if (mon_en) begin
            check(word_start == pend_start, "R7 word_start", longint'(word_start), longint'(pend_start));
            check(word_end == pend_end, "R8 word_end", longint'(word_end), longint'(pend_end));
            check(speech_active == model_active, "R9 speech_active", longint'(speech_active), longint'(model_active));
            pend_start = 0;
            pend_end = 0;
            if (frame_done) begin
                if (frames_seen >= NF) begin
                    check(1'b0, "R4 extra frame", longint'(frames_seen), longint'(NF));
                end else begin
                    longint e;
                    e = exp_e[frames_seen];
                    check(frame_energy == 48'(e), "R1/R2/R3 frame_energy", longint'(frame_energy), e);
                    check(cyc == done_cyc[frames_seen], "R5 frame_done timing", longint'(cyc), longint'(done_cyc[frames_seen]));
                    if (!model_active) begin
                        if (e > longint'(HI)) begin
                            run_cnt++;
                            if (run_cnt == 3) begin
                                pend_start = 1; model_active = 1; run_cnt = 0;
                            end
                        end else run_cnt = 0;
                    end else begin
                        if (e < longint'(LO)) begin
                            run_cnt++;
                            if (run_cnt == 5) begin
                                pend_end = 1; model_active = 0; run_cnt = 0;
                            end
                        end else run_cnt = 0;
                    end
                end
                frames_seen++;
            end
        end
    end

    task automatic check_reset_state(input string tag);
        check(frame_done == 1'b0, {tag, " frame_done"}, longint'(frame_done), 0);
        check(frame_energy == '0, {tag, " frame_energy"}, longint'(frame_energy), 0);
        check(speech_active == 1'b0, {tag, " speech_active"}, longint'(speech_active), 0);
        check(word_start == 1'b0, {tag, " word_start"}, longint'(word_start), 0);
        check(word_end == 1'b0, {tag, " word_end"}, longint'(word_end), 0);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        build_taper();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check_reset_state("R10 initial reset");

        build_run(0);
        reset_model();
        @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1;
        drive_run(1'b0);
        mon_en = 0;
        check(frames_seen == NF, "R4 frame count run A", longint'(frames_seen), longint'(NF));

        // Partial loud frame, then reset mid-frame with samples still arriving
        for (int n = 0; n < 50; n++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_data = (n % 2 == 0) ? 16'h7FFF : 16'h8000;
        end
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_reset_state("R10 mid-frame reset");
        smp_valid = 1'b0;

        build_run(1);
        reset_model();
        @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1;
        drive_run(1'b1);
        mon_en = 0;
        check(frames_seen == NF, "R4 frame count run B", longint'(frames_seen), longint'(NF));
        finish_up();
    end

    initial begin
        #(150000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

endmodule